// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block gathers 72 level-sensitive interrupt lines into one interrupt request for a processor. The lines sit in three banks. Bank 0 is a narrow base bank of 8 lines. Banks 1 and 2 are peripheral banks of 32 lines each. Every line has an enable bit. A single `irq` output goes high while any enabled line is high. Software cannot clear a pending bit; it clears the cause at the source, and the pending bit follows the line.

Software uses a small 32-bit register bus. Each bank has a set-enable address and a clear-enable address, so a write never needs a read-modify-write of the mask. Software first reads a summary word. That word holds the enabled base-bank lines, one flag for each peripheral bank that has an enabled line pending, and direct copies of a few chosen peripheral lines. The shortcut line numbers are parameters. If the summary reads zero, nothing needs servicing. The bus has no handshake: a write takes effect on the clock edge where `bus_we` is high, and `bus_rdata` is a combinational decode of `bus_addr`. There is no back-pressure.

Top module: `banked_intc`

Register map (4-bit word address): 0 summary, 1 raw bank 0, 2 raw bank 1, 3 raw bank 2, 4/5/6 set-enable for bank 0/1/2, 8/9/10 clear-enable for bank 0/1/2.

## Requirements
- R1: After reset, all enable masks read zero and `irq` is low.
- R2: A write to address 4, 5 or 6 (banks 0, 1, 2) sets every enable bit whose data bit is 1 and leaves the others unchanged. A read of that address returns the bank's enable mask.
- R3: A write to address 8, 9 or 10 (banks 0, 1, 2) clears every enable bit whose data bit is 1 and leaves the others unchanged. A read of that address returns the bank's enable mask.
- R4: Reading address 1, 2 or 3 returns the current input lines of bank 0, 1 or 2, whatever the enables are. Bank 0 uses bits 7:0 and the rest read zero.
- R5: Summary bits 7:0 are the bank-0 lines ANDed with the bank-0 enables.
- R6: Summary bit 8 is 1 when any enabled bank-1 line is high. Summary bit 9 is the same for bank 2.
- R7: Summary bits 10+k (k=0..4) copy enabled bank-1 line SC1[k], default lines 7, 9, 10, 18, 19. Bits 15+k (k=0..5) copy enabled bank-2 line SC2[k], default lines 1, 2, 3, 4, 5, 30. Bits 31:21 read zero.
- R8: `irq` is the OR of all enabled high lines in the three banks, taken through one register. It rises and falls one clock after its cause changes. The cause can be a line change or an enable write.
- R9: Addresses 7 and 11 to 15 read zero. Writes to them change no enable.
- R10: The summary word reads zero exactly when no enabled line is high in any bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_base | input | 8 | Bank 0 level lines |
| src_p1 | input | 32 | Bank 1 level lines |
| src_p2 | input | 32 | Bank 2 level lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Enable writes take effect at the clock edge that samples `bus_we`. Raw, summary and readback values are combinational after that. The bench drives inputs on falling edges and reads the bus one step later in the same low phase. It checks the readback and summary at the falling edge right after the write. `irq` passes through one more register. The bench therefore samples it twice: at the falling edge after the cause, where it must still hold its old value, and again one edge later, where it must have changed. This covers both the rise and the fall.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int BASE_W  = 8;
  localparam int SC1_N   = 5;
  localparam int SC2_N   = 6;
  localparam int SUM_USED = BASE_W + 2 + SC1_N + SC2_N;

  typedef enum logic [ADDR_W-1:0] {
    A_SUM  = 4'd0,
    A_RAW0 = 4'd1,
    A_RAW1 = 4'd2,
    A_RAW2 = 4'd3,
    A_EN0  = 4'd4,
    A_EN1  = 4'd5,
    A_EN2  = 4'd6,
    A_DIS0 = 4'd8,
    A_DIS1 = 4'd9,
    A_DIS2 = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_req,
  input  logic         clr_req,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] lines,
  output logic [W-1:0] en_q,
  output logic [W-1:0] act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (set_req) en_q <= en_q | wmask;
    else if (clr_req) en_q <= en_q & ~wmask;
  end

  assign act = lines & en_q;
endmodule

// File: rtl/intc_summary.sv
module intc_summary
  import intc_pkg::*;
#(
  parameter int PERI_W = 32,
  parameter int SC1_LINES [SC1_N] = '{7, 9, 10, 18, 19},
  parameter int SC2_LINES [SC2_N] = '{1, 2, 3, 4, 5, 30}
) (
  input  logic [BASE_W-1:0] act0,
  input  logic [PERI_W-1:0] act1,
  input  logic [PERI_W-1:0] act2,
  output logic [WORD_W-1:0] sum
);
  logic [SC1_N-1:0] sc1;
  logic [SC2_N-1:0] sc2;

  for (genvar k = 0; k < SC1_N; k++) begin : g_sc1
    assign sc1[k] = act1[SC1_LINES[k]];
  end
  for (genvar k = 0; k < SC2_N; k++) begin : g_sc2
    assign sc2[k] = act2[SC2_LINES[k]];
  end

  assign sum = {{(WORD_W-SUM_USED){1'b0}}, sc2, sc1, |act2, |act1, act0};
endmodule

// File: rtl/banked_intc.sv
module banked_intc
  import intc_pkg::*;
#(
  parameter int PERI_W = 32,
  parameter int SC1_LINES [SC1_N] = '{7, 9, 10, 18, 19},
  parameter int SC2_LINES [SC2_N] = '{1, 2, 3, 4, 5, 30}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] src_base,
  input  logic [PERI_W-1:0] src_p1,
  input  logic [PERI_W-1:0] src_p2,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int NPERI = 2;

  logic [BASE_W-1:0]            en0_q, act0;
  logic [NPERI-1:0][PERI_W-1:0] peri_lines, en_peri, act_peri;
  logic [WORD_W-1:0]            sum_word;
  logic                         any_act;

  assign peri_lines[0] = src_p1;
  assign peri_lines[1] = src_p2;

  intc_bank #(.W(BASE_W)) u_bank0 (
    .clk(clk), .rst_n(rst_n),
    .set_req(bus_we && bus_addr == A_EN0),
    .clr_req(bus_we && bus_addr == A_DIS0),
    .wmask(bus_wdata[BASE_W-1:0]),
    .lines(src_base), .en_q(en0_q), .act(act0)
  );

  for (genvar b = 0; b < NPERI; b++) begin : g_peri
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(A_EN1 + b);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(A_DIS1 + b);
    intc_bank #(.W(PERI_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_req(bus_we && bus_addr == SET_A),
      .clr_req(bus_we && bus_addr == CLR_A),
      .wmask(bus_wdata[PERI_W-1:0]),
      .lines(peri_lines[b]), .en_q(en_peri[b]), .act(act_peri[b])
    );
  end

  intc_summary #(
    .PERI_W(PERI_W), .SC1_LINES(SC1_LINES), .SC2_LINES(SC2_LINES)
  ) u_sum (
    .act0(act0), .act1(act_peri[0]), .act2(act_peri[1]), .sum(sum_word)
  );

  assign any_act = (|act0) | (|act_peri);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_act;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SUM:          bus_rdata = sum_word;
      A_RAW0:         bus_rdata[BASE_W-1:0] = src_base;
      A_RAW1:         bus_rdata[PERI_W-1:0] = src_p1;
      A_RAW2:         bus_rdata[PERI_W-1:0] = src_p2;
      A_EN0,  A_DIS0: bus_rdata[BASE_W-1:0] = en0_q;
      A_EN1,  A_DIS1: bus_rdata[PERI_W-1:0] = en_peri[0];
      A_EN2,  A_DIS2: bus_rdata[PERI_W-1:0] = en_peri[1];
      default:        bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int PERI_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [BASE_W-1:0]        src_base,
  input logic [PERI_W-1:0]        src_p1,
  input logic [PERI_W-1:0]        src_p2,
  input logic                     bus_we,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [WORD_W-1:0]        bus_wdata,
  input logic [WORD_W-1:0]        bus_rdata,
  input logic                     irq,
  input logic [BASE_W-1:0]        en0,
  input logic [1:0][PERI_W-1:0]   enp
);
  logic pend_any;
  assign pend_any = (|(src_base & en0)) | (|(src_p1 & enp[0])) | (|(src_p2 & enp[1]));

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && en0 == '0 && enp == '0)); // R1

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_EN1) |=>
      ((enp[0] & $past(bus_wdata[PERI_W-1:0])) == $past(bus_wdata[PERI_W-1:0]))); // R2

  AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_EN2) |=> ((enp[1] & $past(enp[1])) == $past(enp[1]))); // R2

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DIS1) |=> ((enp[0] & $past(bus_wdata[PERI_W-1:0])) == '0)); // R3

  AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == 4'd7 || bus_addr > 4'd10)) |=> ($stable(en0) && $stable(enp))); // R9

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(pend_any))); // R8

  AST_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_SUM) |-> ((bus_rdata == '0) == !pend_any)); // R10

  always_comb begin
    if (rst_n && bus_addr == A_SUM)
      AST_SUM_TOP_CLEAR: assert (bus_rdata[WORD_W-1:SUM_USED] == '0); // R7
  end
endmodule

bind banked_intc intc_chk #(.PERI_W(PERI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_base(src_base), .src_p1(src_p1), .src_p2(src_p2),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .en0(en0_q), .enp(en_peri)
);

// File: tb/banked_intc_test.sv
module banked_intc_test;
  localparam int SC1 [5] = '{7, 9, 10, 18, 19};
  localparam int SC2 [6] = '{1, 2, 3, 4, 5, 30};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_base = '0;
  logic [31:0] src_p1 = '0, src_p2 = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  logic [7:0]  m_en0 = '0;
  logic [31:0] m_en1 = '0, m_en2 = '0;

  banked_intc #(.PERI_W(32), .SC1_LINES(SC1), .SC2_LINES(SC2)) uut (
    .clk(clk), .rst_n(rst_n), .src_base(src_base), .src_p1(src_p1), .src_p2(src_p2),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_sum();
    logic [7:0]  a0 = src_base & m_en0;
    logic [31:0] a1 = src_p1 & m_en1;
    logic [31:0] a2 = src_p2 & m_en2;
    logic [31:0] s = {24'd0, a0};
    s[8] = |a1;
    s[9] = |a2;
    for (int k = 0; k < 5; k++) s[10+k] = a1[SC1[k]];
    for (int k = 0; k < 6; k++) s[15+k] = a2[SC2[k]];
    return s;
  endfunction

  function automatic logic exp_any();
    return (|(src_base & m_en0)) | (|(src_p1 & m_en1)) | (|(src_p2 & m_en2));
  endfunction

  task automatic drive_lines(input int b, input logic [31:0] v);
    @(negedge clk);
    src_base = '0; src_p1 = '0; src_p2 = '0;
    if (b == 0) src_base = v[7:0];
    else if (b == 1) src_p1 = v;
    else src_p2 = v;
  endtask

  task automatic set_model(input int b, input logic [31:0] v, input bit en);
    if (b == 0) m_en0 = en ? (m_en0 | v[7:0]) : (m_en0 & ~v[7:0]);
    else if (b == 1) m_en1 = en ? (m_en1 | v) : (m_en1 & ~v);
    else m_en2 = en ? (m_en2 | v) : (m_en2 & ~v);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 4; a <= 6; a++) begin
      rd(4'(a), r); chk("R1 enable after reset", r, 32'd0);
    end
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(4'd0, r); chk("R10 summary idle", r, 32'd0);

    // Per-line sweep over all banks
    for (int b = 0; b < 3; b++) begin
      for (int i = 0; i < (b == 0 ? 8 : 32); i++) begin
        logic [31:0] bit_v = 32'd1 << i;
        drive_lines(b, bit_v);
        rd(4'(1 + b), r); chk("R4 raw pending while disabled", r, bit_v);
        rd(4'd0, r); chk("R10 summary zero while disabled", r, 32'd0);
        wr(4'(4 + b), bit_v); set_model(b, bit_v, 1'b1);
        chk("R8 irq still low one edge after enable", {31'd0, irq}, 32'd0);
        rd(4'(4 + b), r); chk("R2 enable readback", r, bit_v);
        rd(4'd0, r);
        chk(b == 0 ? "R5 summary base bit" : "R6 R7 summary bank flag and shortcut", r, exp_sum());
        @(negedge clk);
        chk("R8 irq high after one cycle", {31'd0, irq}, 32'd1);
        wr(4'(8 + b), bit_v); set_model(b, bit_v, 1'b0);
        chk("R8 irq still high one edge after disable", {31'd0, irq}, 32'd1);
        rd(4'(8 + b), r); chk("R3 disable readback", r, 32'd0);
        rd(4'(1 + b), r); chk("R4 raw pending survives disable", r, bit_v);
        @(negedge clk);
        chk("R8 irq low after disable", {31'd0, irq}, 32'd0);
      end
    end
    drive_lines(0, 32'd0);

    // Random mixed patterns with all three banks
    for (int n = 0; n < 60; n++) begin
      logic [31:0] e0 = $urandom, e1 = $urandom, e2 = $urandom;
      logic [31:0] d0 = $urandom, d1 = $urandom, d2 = $urandom;
      wr(4'd4, e0); set_model(0, e0, 1'b1);
      wr(4'd9, e1); set_model(1, e1, 1'b0);
      wr(4'd6, e2); set_model(2, e2, 1'b1);
      wr(4'd5, e1 & e2); set_model(1, e1 & e2, 1'b1);
      if (n % 4 == 0) begin d1 = 32'd0; d2 = 32'd0; d0 = d0 & {24'd0, ~m_en0}; end
      @(negedge clk);
      src_base = d0[7:0]; src_p1 = d1 & (n % 3 == 0 ? 32'h000C0680 : 32'hFFFFFFFF); src_p2 = d2;
      rd(4'd5, r); chk("R2 R3 mixed enable readback", r, m_en1);
      rd(4'd10, r); chk("R3 readback via disable address", r, m_en2);
      rd(4'd0, r); chk("R7 R10 summary mixed", r, exp_sum());
      rd(4'd2, r); chk("R4 raw bank1", r, src_p1);
      rd(4'd1, r); chk("R4 raw bank0", r, {24'd0, src_base});
      @(negedge clk);
      chk("R8 irq mixed", {31'd0, irq}, {31'd0, exp_any()});
    end

    // R2 R3 zero writes
    wr(4'd5, 32'd0); wr(4'd9, 32'd0); wr(4'd4, 32'd0); wr(4'd10, 32'd0);
    rd(4'd5, r); chk("R2 zero write no effect", r, m_en1);
    rd(4'd8, r); chk("R3 zero write no effect", r, {24'd0, m_en0});
    rd(4'd6, r); chk("R3 zero write no effect bank2", r, m_en2);

    // R9 unmapped addresses
    for (int a = 7; a < 16; a++) begin
      if (a == 8 || a == 9 || a == 10) continue;
      wr(4'(a), 32'hFFFFFFFF);
      rd(4'(a), r); chk("R9 unmapped reads zero", r, 32'd0);
    end
    rd(4'd4, r); chk("R9 bank0 untouched", r, {24'd0, m_en0});
    rd(4'd5, r); chk("R9 bank1 untouched", r, m_en1);
    rd(4'd6, r); chk("R9 bank2 untouched", r, m_en2);

    // R7 every shortcut together with upper bits zero
    wr(4'd5, 32'hFFFFFFFF); set_model(1, 32'hFFFFFFFF, 1'b1);
    wr(4'd6, 32'hFFFFFFFF); set_model(2, 32'hFFFFFFFF, 1'b1);
    @(negedge clk);
    src_p1 = 32'hFFFFFFFF; src_p2 = 32'hFFFFFFFF; src_base = 8'h00;
    rd(4'd0, r); chk("R7 all shortcuts, top bits zero", r, {11'd0, 6'h3F, 5'h1F, 2'b11, 8'h00});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule